// File: doc/BRIEF.md
# Dual Bi-Quinary Decade Counter

The block holds two decade counters that share nothing but the system clock and the system reset. Each counter has two stages. A one-bit toggle stage drives output QA and is advanced by count input A. A modulo-five stage drives QB, QC and QD and is advanced by count input B. The two count inputs are separate, so the feedback wiring outside the block sets the code. If QA drives input B and pulses go into A, the counter runs in binary-coded decimal. If QD drives input A and pulses go into B, the counter runs in a bi-quinary code, and QA is a symmetrical square wave at one tenth of the input rate.

The whole block runs on one system clock. The count inputs are ordinary data signals. Each count input is registered, and a stage advances when a high-to-low transition is seen between two samples in a row. Each counter has its own active-high, asynchronous clear. The clear empties that counter and its edge history at once, and it wins over any count in the same cycle.

Top module: `dual_decade_counter`

## Requirements
- R1: After the system reset, every output of both counters is low.
- R2: Each falling transition of a counter's A input toggles that counter's QA exactly once. Rising transitions and steady levels on A leave QA unchanged.
- R3: Each falling transition of a counter's B input steps {QD,QC,QB} through 000, 001, 010, 011, 100 and then back to 000. QA is unaffected.
- R4: An output that changes in response to a count input does so on the second rising system-clock edge after the input is first sampled low. The output keeps its old value after the first of those edges.
- R5: While a counter's clear is high, all four of its outputs are low. This takes effect without waiting for a clock edge and holds whatever the count inputs do.
- R6: Releasing a clear never produces a count by itself, whether the count inputs are high or low at release. The first falling transition after release counts normally.
- R7: Count inputs and clear of one counter have no effect on the outputs of the other counter.
- R8: With QA fed back to B and pulses on A, the outputs {QD,QC,QB,QA} read as a binary number that runs 0 to 9 and wraps to 0, one step per pulse.
- R9: With QD fed back to A and pulses on B, after n pulses from clear QA equals ((n mod 10) >= 5) and {QD,QC,QB} equals n mod 5. QA is therefore high for exactly five pulses in every ten.
- R10: The modulo-five stage never holds a value above 100. If it ever held 101, 110 or 111, the next B edge would return it to 000.
- R11: Output bus q_o carries counter k at bits 4k+3..4k, in the order QD, QC, QB, QA from the top bit down. Input bit k of each input bus belongs to counter k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all sampling and state changes happen on its rising edge |
| rst_n | input | 1 | Asynchronous system reset, active low |
| clr_i | input | NUM_CNT | Per-counter asynchronous clear, active high |
| cnt_a_i | input | NUM_CNT | Per-counter count input of the toggle stage |
| cnt_b_i | input | NUM_CNT | Per-counter count input of the modulo-five stage |
| q_o | output | 4*NUM_CNT | Counter outputs, four bits per counter as {QD,QC,QB,QA} |

## Verification
The embedded assertions check on every cycle the following. A detected edge comes only from a high-then-low pair of samples. Each stage steps once per edge and holds between edges. The modulo-five value stays in range. The outputs are zero while a clear is high and on the edge where it is released. The full code sequences come from wiring outside the block, so only the bench's scenarios can show them. The same holds for the two-cycle response and the independence of the two counters. The bench runs the feedback loops through 30 pulses in each mode, with a clear in mid-count, and compares them with arithmetic models.

// File: rtl/dqc_pkg.sv
package dqc_pkg;

  localparam int unsigned QUIN_W    = 3;
  localparam int unsigned QUIN_LAST = 4;
  localparam int unsigned DEC_W     = 4;

  typedef logic [QUIN_W-1:0] quin_t;

  typedef struct packed {
    logic qd;
    logic qc;
    logic qb;
    logic qa;
  } dec_out_t;

  // Successor in the modulo-five ring; any illegal value falls back to zero.
  function automatic quin_t quin_next(input quin_t cur);
    if (cur >= quin_t'(QUIN_LAST)) return '0;
    return cur + quin_t'(1);
  endfunction

  function automatic logic quin_legal(input quin_t v);
    return v <= quin_t'(QUIN_LAST);
  endfunction

  function automatic dec_out_t pack_outputs(input logic bin, input quin_t quin);
    dec_out_t o;
    o.qa = bin;
    o.qb = quin[0];
    o.qc = quin[1];
    o.qd = quin[2];
    return o;
  endfunction

endpackage

// File: rtl/fall_detect.sv
module fall_detect (
  input  logic clk,
  input  logic arst,
  input  logic din,
  output logic fall_o
);

  logic smp_q;
  logic hist_q;

  // History clears to zero: a fall needs a high sample taken after release.
  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      smp_q  <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      smp_q  <= din;
      hist_q <= smp_q;
    end
  end

  assign fall_o = hist_q & ~smp_q;

  // R2
  fall_from_high_low_chk: assert property (@(posedge clk) disable iff (arst)
    fall_o |-> (!$past(din) && $past(din, 2)));

  // R6
  no_fall_after_clear_chk: assert property (@(posedge clk) disable iff (arst)
    $past(arst) |-> !fall_o);

endmodule

// File: rtl/bin_stage.sv
module bin_stage (
  input  logic clk,
  input  logic arst,
  input  logic adv,
  output logic q_o
);

  logic q_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) q_q <= 1'b0;
    else if (adv) q_q <= ~q_q;
  end

  assign q_o = q_q;

  // R2
  bin_toggle_chk: assert property (@(posedge clk) disable iff (arst)
    adv |=> (q_o != $past(q_o)));

  // R2
  bin_hold_chk: assert property (@(posedge clk) disable iff (arst)
    !adv |=> $stable(q_o));

endmodule

// File: rtl/quin_stage.sv
module quin_stage
  import dqc_pkg::*;
(
  input  logic  clk,
  input  logic  arst,
  input  logic  adv,
  output quin_t q_o
);

  quin_t st_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) st_q <= '0;
    else if (adv) st_q <= quin_next(st_q);
  end

  assign q_o = st_q;

  // R10
  quin_range_chk: assert property (@(posedge clk) disable iff (arst)
    q_o <= quin_t'(QUIN_LAST));

  // R3
  quin_wrap_chk: assert property (@(posedge clk) disable iff (arst)
    (adv && q_o == quin_t'(QUIN_LAST)) |=> (q_o == '0));

  // R3
  quin_step_chk: assert property (@(posedge clk) disable iff (arst)
    (adv && q_o < quin_t'(QUIN_LAST)) |=> (q_o == $past(q_o) + quin_t'(1)));

  // R3
  quin_hold_chk: assert property (@(posedge clk) disable iff (arst)
    !adv |=> $stable(q_o));

endmodule

// File: rtl/decade_unit.sv
module decade_unit
  import dqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     cnt_a,
  input  logic     cnt_b,
  output dec_out_t q_o
);

  logic  arst;
  logic  fall_a;
  logic  fall_b;
  logic  bin_q;
  quin_t quin_q;

  assign arst = clr | ~rst_n;

  fall_detect u_edge_a (
    .clk    (clk),
    .arst   (arst),
    .din    (cnt_a),
    .fall_o (fall_a)
  );

  fall_detect u_edge_b (
    .clk    (clk),
    .arst   (arst),
    .din    (cnt_b),
    .fall_o (fall_b)
  );

  bin_stage u_bin (
    .clk  (clk),
    .arst (arst),
    .adv  (fall_a),
    .q_o  (bin_q)
  );

  quin_stage u_quin (
    .clk  (clk),
    .arst (arst),
    .adv  (fall_b),
    .q_o  (quin_q)
  );

  assign q_o = pack_outputs(bin_q, quin_q);

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (q_o == '0));

  // R6
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clr) && !clr) |-> (q_o == '0));

  // R3
  a_leaves_quin_chk: assert property (@(posedge clk) disable iff (arst)
    (fall_a && !fall_b) |=> (quin_q == $past(quin_q)));

endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
  import dqc_pkg::*;
#(
  parameter int unsigned NUM_CNT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CNT-1:0]       clr_i,
  input  logic [NUM_CNT-1:0]       cnt_a_i,
  input  logic [NUM_CNT-1:0]       cnt_b_i,
  output logic [DEC_W*NUM_CNT-1:0] q_o
);

  localparam int unsigned OUT_W = DEC_W * NUM_CNT;

  dec_out_t unit_q [NUM_CNT];

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_unit
    decade_unit u_dec (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_i[k]),
      .cnt_a (cnt_a_i[k]),
      .cnt_b (cnt_b_i[k]),
      .q_o   (unit_q[k])
    );
    assign q_o[DEC_W*k +: DEC_W] = unit_q[k];
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (q_o == OUT_W'(0)));

endmodule

// File: tb/dual_decade_counter_test.sv
module dual_decade_counter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] clr = 2'b00;
  logic [1:0] a_drv = 2'b00;
  logic [1:0] b_drv = 2'b00;
  logic       fb_on = 1'b0;
  logic [1:0] cnt_a;
  logic [1:0] cnt_b;
  logic [7:0] q;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  // Counter 0: binary-coded decimal loop (QA -> B); counter 1: bi-quinary loop (QD -> A).
  always_comb begin
    cnt_a[0] = a_drv[0];
    cnt_b[0] = fb_on ? q[0] : b_drv[0];
    cnt_a[1] = fb_on ? q[7] : a_drv[1];
    cnt_b[1] = b_drv[1];
  end

  dual_decade_counter #(.NUM_CNT(2)) uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .cnt_a_i (cnt_a),
    .cnt_b_i (cnt_b),
    .q_o     (q)
  );

  task automatic check(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [3:0] bq_model(input int n);
    int m;
    m = n % 10;
    return {m[2:0] == 3'd0 ? 1'b0 : 1'b0, 3'b000} | {(m >= 5) ? 1'b0 : 1'b0, 3'b000}
           | {1'b0, 3'(n % 5)} << 1 | {3'b000, (m >= 5)};
  endfunction

  initial begin
    logic [3:0] exp0;
    int bcd_n;
    int bq_n;
    int qa_high;
    cyc(3);
    check(q[3:0] == 4'h0, "R1", q[3:0], 4'h0);
    check(q[7:4] == 4'h0, "R1", q[7:4], 4'h0);
    rst_n = 1'b1;
    cyc(2);

    // R2: a rising edge on A must not count
    a_drv[0] = 1'b1;
    cyc(4);
    check(q[3:0] == 4'h0, "R2 rise", q[3:0], 4'h0);
    // R4: fall of A seen after the second edge only
    a_drv[0] = 1'b0;
    cyc(1);
    check(q[3:0] == 4'h0, "R4 early", q[3:0], 4'h0);
    cyc(1);
    check(q[3:0] == 4'h1, "R4 R11 QA", q[3:0], 4'h1);
    cyc(4);
    check(q[3:0] == 4'h1, "R2 hold", q[3:0], 4'h1);

    // R3: direct B pulses, QA stays set
    for (int k = 1; k <= 7; k++) begin
      b_drv[0] = 1'b1;
      cyc(3);
      b_drv[0] = 1'b0;
      cyc(3);
      exp0 = {3'(k % 5), 1'b1};
      check(q[3:0] == exp0, "R3 R10", q[3:0], exp0);
    end
    // R7: counter 1 untouched
    check(q[7:4] == 4'h0, "R7", q[7:4], 4'h0);

    // R5: clear acts without a clock edge, mid-count
    #2 clr[0] = 1'b1;
    #1 check(q[3:0] == 4'h0, "R5 async", q[3:0], 4'h0);
    cyc(1);
    a_drv[0] = 1'b1; b_drv[0] = 1'b1;
    cyc(3);
    a_drv[0] = 1'b0; b_drv[0] = 1'b0;
    cyc(3);
    check(q[3:0] == 4'h0, "R5 held", q[3:0], 4'h0);
    // R6: release with A high, no count
    a_drv[0] = 1'b1;
    cyc(3);
    clr[0] = 1'b0;
    cyc(5);
    check(q[3:0] == 4'h0, "R6 high", q[3:0], 4'h0);
    a_drv[0] = 1'b0;
    cyc(3);
    check(q[3:0] == 4'h1, "R6 first", q[3:0], 4'h1);
    // R6: release with inputs low
    clr[0] = 1'b1;
    cyc(2);
    clr[0] = 1'b0;
    cyc(5);
    check(q[3:0] == 4'h0, "R6 low", q[3:0], 4'h0);

    // R7: counter 1 driven alone, counter 0 stays put
    a_drv[1] = 1'b1;
    cyc(2);
    a_drv[1] = 1'b0;
    cyc(3);
    check(q[7:4] == 4'h1, "R7 c1", q[7:4], 4'h1);
    check(q[3:0] == 4'h0, "R7 c0", q[3:0], 4'h0);

    // Feedback loops from a clear
    clr = 2'b11;
    cyc(2);
    fb_on = 1'b1;
    cyc(2);
    clr = 2'b00;
    cyc(3);
    bcd_n = 0;
    bq_n = 0;
    qa_high = 0;
    for (int p = 1; p <= 30; p++) begin
      a_drv[0] = 1'b1; b_drv[1] = 1'b1;
      cyc(5);
      a_drv[0] = 1'b0; b_drv[1] = 1'b0;
      cyc(10);
      bcd_n++;
      bq_n++;
      exp0 = 4'(bcd_n % 10);
      check(q[3:0] == exp0, "R8", q[3:0], exp0);
      exp0 = {3'(bq_n % 5), ((bq_n % 10) >= 5)};
      check({q[7:5], q[4]} == exp0, "R9", {q[7:5], q[4]}, exp0);
      if (p > 13 && p <= 23 && q[4]) qa_high++;
      if (p == 13) begin
        // mid-count clear in both loops
        clr = 2'b11;
        #1 check(q == 8'h00, "R5 loop", q[3:0], 4'h0);
        cyc(3);
        clr = 2'b00;
        cyc(6);
        check(q == 8'h00, "R6 loop", q[7:4], 4'h0);
        bcd_n = 0;
        bq_n = 0;
      end
    end
    check(qa_high == 5, "R9 duty", 4'(qa_high), 4'd5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule